// File: doc/BRIEF.md
# Prescaled Reloading Periodic Timer

This block produces a steady periodic event from a slow reference tick. The reference tick (a one-cycle enable in the system clock domain) goes through a power-of-two prescaler that yields a base tick. A 16-bit down-counter steps on every base tick. When the counter is found at zero on a base tick, it reloads from a programmable preset and emits a one-cycle wrap pulse. Each wrap sets a sticky terminal-count flag, and that flag, when enabled, drives a level interrupt.

Software controls the block through a small synchronous register bus with separate read and write strobes. Three registers are visible: the divide code, the 16-bit preset, and a control/status word. The control/status word holds a one-shot restart request, the terminal-count flag and the interrupt enable. Reading the control/status word clears the terminal-count flag. The whole block runs on one system clock. The base and wrap ticks are enable pulses, not derived clocks. There is no streaming data path, so no valid/ready handshake applies; all pins are plain control and status.

Top module: `ptmr_top`

## Requirements
- R1: After reset the divide code reads 0, the preset reads FFFF hex, the control/status word reads 0, and the counter holds FFFF hex.
- R2: With divide code k (0 to 5), `base_tick` pulses in the same cycle as every 2^k-th `ref_tick`. A write of a valid code restarts the prescaler phase, so the first base tick after the write comes on the 2^k-th reference tick that follows it.
- R3: A write of divide code 6 or 7 is ignored. The divisor in use and the value read back at address 0 both stay as they were.
- R4: On a base tick, a nonzero counter decrements by one. A counter at zero reloads from the preset and raises `wrap_tick` in that same cycle, so wraps repeat every PRESET+1 base ticks. The counter does not change between base ticks.
- R5: Writing the preset does not disturb the running count. The new value is used at the next reload.
- R6: Writing 1 to control bit 0 (restart) sets a pending request. On the next base tick the counter reloads from the preset with no wrap pulse, and the bit clears. Writing 0 to bit 0 leaves the request as it is.
- R7: Control bit 1 (terminal count) is set by every wrap. A read of address 2 clears it. If a wrap and that read fall in the same cycle, the bit ends set. Writes to bit 1 are ignored.
- R8: Control bit 2 is the interrupt enable. `irq` is high exactly while both the terminal-count bit and the enable bit are set.
- R9: Address map: 0 holds the divide code in bits 2:0, 1 holds the preset in bits 15:0, 2 holds the control/status word, and 3 reads as 0. `rdata` shows the addressed register in the same cycle as `rd_en` and is 0 when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Slow reference enable pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with rd_en |
| base_tick | output | 1 | Prescaled tick pulse |
| wrap_tick | output | 1 | Counter reload pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The bound checker checks these rules on every cycle: a base tick only comes with a reference tick; a wrap only comes with a base tick; the count is stable between base ticks; a wrap always loads the preset that was in place before it and sets the terminal-count flag; a consumed restart clears itself; and a reserved code never changes the divisor. The end-to-end timing needs the bench's scenarios. This covers the wrap spacing for a given preset and divisor, the phase restart after a divide write, a preset change that only takes effect at the next reload, and a status read that lands in the same cycle as a wrap.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned MAX_LOG = 5;

  localparam logic [ADDR_W-1:0] A_DIV    = 2'd0;
  localparam logic [ADDR_W-1:0] A_PRESET = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

  localparam int unsigned B_RESTART = 0;
  localparam int unsigned B_TC      = 1;
  localparam int unsigned B_IE      = 2;

  typedef struct packed {
    logic ie;
    logic tc;
    logic restart;
  } ctrl_t;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int unsigned CODE_W  = 3,
  parameter int unsigned MAX_LOG = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q,
  output logic              base_tick
);
  localparam int unsigned PH_W = (MAX_LOG > 0) ? MAX_LOG : 1;

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] mask;
  logic            code_ok;
  logic            at_end;

  // Build the phase mask from the exponent: bit i set when code > i.
  generate
    for (genvar i = 0; i < PH_W; i++) begin : g_mask
      assign mask[i] = (code_q > CODE_W'(i));
    end
  endgenerate

  assign code_ok   = (code_in <= CODE_W'(MAX_LOG));
  assign at_end    = (phase_q == mask);
  assign base_tick = ref_tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      phase_q <= '0;
    end else begin
      if (ref_tick) begin
        phase_q <= at_end ? '0 : phase_q + 1'b1;
      end
      if (code_wr && code_ok) begin
        code_q  <= code_in;
        phase_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             restart_pend,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count_q,
  output logic             wrap_tick,
  output logic             restart_take
);
  logic at_zero;

  assign at_zero      = (count_q == '0);
  assign restart_take = base_tick && restart_pend;
  assign wrap_tick    = base_tick && !restart_pend && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '1;
    end else if (base_tick) begin
      if (restart_pend || at_zero) count_q <= preset;
      else                         count_q <= count_q - 1'b1;
    end
  end
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [CODE_W-1:0] code_q,
  input  logic              wrap_tick,
  input  logic              restart_take,
  output logic              code_wr,
  output logic [CODE_W-1:0] code_in,
  output logic [CNT_W-1:0]  preset_q,
  output ctrl_t             ctrl_q,
  output logic              irq
);
  logic wr_preset, wr_ctrl, rd_ctrl;

  assign code_wr   = wr_en && (addr == A_DIV);
  assign code_in   = wdata[CODE_W-1:0];
  assign wr_preset = wr_en && (addr == A_PRESET);
  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign rd_ctrl   = rd_en && (addr == A_CTRL);
  assign irq       = ctrl_q.tc && ctrl_q.ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '1;
      ctrl_q   <= '0;
    end else begin
      if (wr_preset) preset_q <= wdata[CNT_W-1:0];
      // restart: consumed by a base tick, re-armed only by writing a 1
      if (restart_take)                 ctrl_q.restart <= 1'b0;
      if (wr_ctrl && wdata[B_RESTART])  ctrl_q.restart <= 1'b1;
      if (wr_ctrl)                      ctrl_q.ie      <= wdata[B_IE];
      // terminal count: read clears, a new wrap wins
      if (rd_ctrl)   ctrl_q.tc <= 1'b0;
      if (wrap_tick) ctrl_q.tc <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        A_DIV:    rdata = DATA_W'(code_q);
        A_PRESET: rdata = DATA_W'(preset_q);
        A_CTRL:   rdata = DATA_W'(ctrl_q);
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              base_tick,
  output logic              wrap_tick,
  output logic              irq
);
  logic              code_wr;
  logic [CODE_W-1:0] code_in;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  preset_q;
  logic [CNT_W-1:0]  count_q;
  ctrl_t             ctrl_q;
  logic              restart_take;

  ptmr_prescaler #(.CODE_W(CODE_W), .MAX_LOG(MAX_LOG)) u_pre (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .code_wr(code_wr), .code_in(code_in),
    .code_q(code_q), .base_tick(base_tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
    .restart_pend(ctrl_q.restart), .preset(preset_q),
    .count_q(count_q), .wrap_tick(wrap_tick), .restart_take(restart_take)
  );

  ptmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .code_q(code_q), .wrap_tick(wrap_tick), .restart_take(restart_take),
    .code_wr(code_wr), .code_in(code_in),
    .preset_q(preset_q), .ctrl_q(ctrl_q), .irq(irq)
  );
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
  import ptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              base_tick,
  input logic              wrap_tick,
  input logic [CODE_W-1:0] code_q,
  input logic [CNT_W-1:0]  count_q,
  input logic [CNT_W-1:0]  preset_q,
  input ctrl_t             ctrl_q
);
  AST_BASE_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |-> ref_tick); // R2

  AST_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIV && wdata[CODE_W-1:0] > CODE_W'(MAX_LOG)) |=> $stable(code_q)); // R3

  AST_WRAP_ON_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_tick |-> base_tick); // R4

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !base_tick |=> $stable(count_q)); // R4

  AST_RELOAD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_tick |=> (count_q == $past(preset_q))); // R5

  AST_RESTART_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && ctrl_q.restart && !(wr_en && addr == A_CTRL && wdata[B_RESTART]))
      |=> !ctrl_q.restart); // R6

  AST_TC_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_tick |=> ctrl_q.tc); // R7
endmodule

bind ptmr_top ptmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .base_tick(base_tick), .wrap_tick(wrap_tick),
  .code_q(code_q), .count_q(count_q), .preset_q(preset_q), .ctrl_q(ctrl_q)
);

// File: tb/tb_ptmr_top.sv
module tb_ptmr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        base_tick, wrap_tick, irq;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  // behavioural reference state
  int m_code, m_ph, m_preset, m_cnt;
  bit m_rp, m_tc, m_ie;
  int wraps_seen;

  always #5 clk = ~clk;

  ptmr_top dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .base_tick(base_tick), .wrap_tick(wrap_tick), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic int mask_of(int c);
    return (1 << c) - 1;
  endfunction

  function automatic bit pred_base(bit r);
    return r && (m_ph == mask_of(m_code));
  endfunction

  function automatic bit pred_wrap(bit r);
    return pred_base(r) && !m_rp && (m_cnt == 0);
  endfunction

  // One cycle: drive at negedge, compare, advance model at posedge.
  task automatic step(input bit r, input bit w, input bit rd, input int a,
                      input int d, input string rtag);
    int  exp_rd;
    bit  bt, wt;
    ref_tick = r; wr_en = w; rd_en = rd; addr = a[1:0]; wdata = d[15:0];
    #1;
    bt = pred_base(r);
    wt = pred_wrap(r);
    exp_rd = 0;
    if (rd) begin
      case (a)
        0: exp_rd = m_code;
        1: exp_rd = m_preset;
        2: exp_rd = (int'(m_ie) << 2) | (int'(m_tc) << 1) | int'(m_rp);
        default: exp_rd = 0;
      endcase
    end
    check("R2 base_tick", int'(base_tick), int'(bt));
    check("R4 wrap_tick", int'(wrap_tick), int'(wt));
    check("R8 irq", int'(irq), int'(m_tc && m_ie));
    check(rtag, int'(rdata), exp_rd);
    if (wt) wraps_seen++;
    @(posedge clk);
    if (r) m_ph = (m_ph == mask_of(m_code)) ? 0 : m_ph + 1;
    if (w && a == 0 && (d & 7) <= 5) begin m_code = d & 7; m_ph = 0; end
    if (bt) begin
      if (m_rp) begin m_cnt = m_preset; m_rp = 0; end
      else if (m_cnt == 0) m_cnt = m_preset;
      else m_cnt = m_cnt - 1;
    end
    if (w && a == 1) m_preset = d & 16'hFFFF;
    if (w && a == 2) begin
      if (d & 1) m_rp = 1;
      m_ie = (d >> 2) & 1;
    end
    if (rd && a == 2) m_tc = 0;
    if (wt) m_tc = 1;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit r);
    for (int i = 0; i < n; i++) step(r, 0, 0, 0, 0, "R9 rdata idle");
  endtask

  initial begin
    m_code = 0; m_ph = 0; m_preset = 16'hFFFF; m_cnt = 16'hFFFF;
    m_rp = 0; m_tc = 0; m_ie = 0; wraps_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values, R9 address map
    step(0, 0, 1, 0, 0, "R1 reset div code");
    step(0, 0, 1, 1, 0, "R1 reset preset");
    step(0, 0, 1, 2, 0, "R1 reset ctrl");
    step(0, 0, 1, 3, 0, "R9 unused address");

    // preset 3, restart, divide by 1: wrap every 4 ticks
    step(0, 1, 0, 1, 3, "R5 preset write");
    step(0, 1, 0, 2, 1, "R6 restart write");
    step(0, 0, 1, 2, 0, "R6 restart pending readback");
    wraps_seen = 0;
    idle(21, 1);
    check("R4 wraps in 21 ticks", wraps_seen, 5);
    step(0, 0, 1, 2, 0, "R7 tc set after wraps");
    step(0, 0, 1, 2, 0, "R7 tc cleared by read");

    // R7 writes to tc ignored; R8 irq enable
    step(0, 1, 0, 2, 2, "R7 tc write ignored");
    step(0, 0, 1, 2, 0, "R7 tc still clear");
    step(0, 1, 0, 2, 4, "R8 enable irq");
    while (!pred_wrap(1)) step(1, 0, 0, 0, 0, "R9 rdata idle");
    step(1, 0, 0, 0, 0, "R4 wrap with irq");
    check("R8 irq after wrap", int'(irq), 1);
    // R7 read in the same cycle as a wrap: flag stays set
    while (!pred_wrap(1)) step(1, 0, 0, 0, 0, "R9 rdata idle");
    step(1, 0, 1, 2, 0, "R7 read coincident with wrap");
    step(0, 0, 1, 2, 0, "R7 tc survives coincident read");
    step(0, 0, 1, 2, 0, "R7 tc cleared");

    // R6 writing 0 to restart has no effect
    step(0, 1, 0, 2, 4, "R6 restart write zero");
    step(0, 0, 1, 2, 0, "R6 no pending after zero write");

    // R5 preset change mid-count
    step(0, 1, 0, 1, 6, "R5 preset change");
    idle(20, 1);

    // R2 divide by 4, sparse reference ticks
    step(0, 1, 0, 0, 2, "R2 div code write");
    step(0, 0, 1, 0, 0, "R2 div code readback");
    for (int i = 0; i < 60; i++) step(i % 2 == 0, 0, 0, 0, 0, "R9 rdata idle");

    // R3 reserved codes
    step(0, 1, 0, 0, 6, "R3 reserved write 6");
    step(0, 0, 1, 0, 0, "R3 code unchanged after 6");
    step(1, 1, 0, 0, 7, "R3 reserved write 7");
    step(0, 0, 1, 0, 0, "R3 code unchanged after 7");
    idle(30, 1);

    // R2 max divisor 32 with restart
    step(1, 1, 0, 0, 5, "R2 div code 32");
    step(0, 1, 0, 2, 5, "R6 restart again");
    idle(250, 1);
    step(0, 0, 1, 2, 0, "R7 tc final");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule